// File: doc/BRIEF.md
# Multi-dimensional matrix index remapper

This block turns the steps of a linear vector loop (0, 1, 2, ... up to a requested length minus one) into the element indices of a walk over a 1D, 2D or 3D array. One 32-bit shape word sets up the walk. It gives the three axis sizes, the order in which the three loops nest, a per-axis count direction, an axis to leave out of the result, and a constant added to every index. Sizes need not be powers of two. The walk can be reshaped so that matrix transposes, rotations and multiply operand orders come out of a single loop.

A consumer pulses `start_i` with a shape word and a loop length. The block then offers one index at a time on `idx_o` while `idx_valid_o` is high, and moves on each time `step_i` is high at a clock edge. Once the requested number of steps has been accepted, `done_o` rises and the block holds until the next start.

Top module: `mdr_matrix_remap`

## Requirements
- R1: While reset is asserted, and after it, until the first start, `idx_valid_o` and `done_o` are 0.
- R2: A start loads the shape word and the length. From the next cycle the block presents step 0, with `idx_valid_o` high and `done_o` low. A start has priority over everything else, including a walk that is already running.
- R3: The sizes sit in shape bits 5:0 (x), 11:6 (y) and 17:12 (z). Each holds the axis length minus one. With nesting order x innermost, the index is x + (X)·y + (X·Y)·z, where X, Y and Z are the axis lengths.
- R4: Shape bits 20:18 choose the nesting order, listed innermost first: 000 x,y,z; 001 x,z,y; 010 y,x,z; 011 y,z,x; 100 z,x,y; 101 z,y,x. Codes 110 and 111 behave as 000. Each axis is weighted by the product of the lengths of the kept axes nested inside it.
- R5: Shape bit 21+k (k=0 for x, 1 for y, 2 for z) makes that axis run from its length minus one down to 0 instead of from 0 up.
- R6: Shape bits 29:28 drop one axis from the index: 01 drops x, 10 drops y, 11 drops z, and 00 drops none. A dropped axis adds nothing to the index and to no weight. This produces repeated values (0 0 0 1 1 1 ...) or modulo wrapping (0 1 2 0 1 2 ...).
- R7: Shape bits 27:24 hold an offset of 0 to 15 that is added to every remapped index.
- R8: An all-zero shape word turns remapping off, and the index equals the step number.
- R9: A step is taken only on a clock edge where `step_i` is high and an index is valid. Without it, the index is held.
- R10: After the number of accepted steps reaches the length, `done_o` is 1 and `idx_valid_o` is 0 until the next start. A length of 0 gives `done_o` in the cycle after the start.
- R11: When the length exceeds the array size, the walk starts over from the first element and continues cyclically. The length field is 7 bits, so at most 127 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load shape and length, restart the walk |
| vl_i | input | 7 | Loop length in steps |
| shape_i | input | 32 | Shape word |
| step_i | input | 1 | Consumer takes the current index |
| idx_valid_o | output | 1 | An index is being offered |
| idx_o | output | 19 | Remapped element index |
| done_o | output | 1 | All requested steps taken |

## Verification
Directed walks cover specific cases. A transposed 3x2 array shows that the nesting order is applied. Repeat and modulo sequences show that the dropped axis is removed from both the sum and the weights. A reversed axis and an offset are tried alone, so that each is seen on its own. A zero shape shows the bypass path, and a 127-step walk over an 8-element array shows the cyclic wrap. A length of zero and a restart in the middle of a walk show the start and end handling. Random shapes with small sizes then mix every field together. Random gaps between steps show that the index holds while no step is taken.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  localparam int AXES  = 3;
  localparam int DIM_W = 6;

  typedef logic [1:0] axis_t;

  typedef struct packed {
    logic [1:0]       mode;
    logic [1:0]       skip;
    logic [3:0]       ofs;
    logic [2:0]       inv;
    logic [2:0]       perm;
    logic [DIM_W-1:0] zsz;
    logic [DIM_W-1:0] ysz;
    logic [DIM_W-1:0] xsz;
  } shape_t;

  // Axis found at nesting position pos (0 = innermost) for a permute code.
  function automatic axis_t nest_axis(input logic [2:0] perm, input int pos);
    logic [5:0] ord; // {outer, middle, inner}
    case (perm)
      3'b001:  ord = {2'd1, 2'd2, 2'd0};
      3'b010:  ord = {2'd2, 2'd0, 2'd1};
      3'b011:  ord = {2'd0, 2'd2, 2'd1};
      3'b100:  ord = {2'd1, 2'd0, 2'd2};
      3'b101:  ord = {2'd0, 2'd1, 2'd2};
      default: ord = {2'd2, 2'd1, 2'd0};
    endcase
    return ord[2*pos +: 2];
  endfunction

  function automatic logic [DIM_W-1:0] axis_size(input shape_t sh, input axis_t a);
    case (a)
      2'd1:    return sh.ysz;
      2'd2:    return sh.zsz;
      default: return sh.xsz;
    endcase
  endfunction

endpackage

// File: rtl/mdr_nest_walk.sv
module mdr_nest_walk
  import mdr_pkg::*;
#(
  parameter int CW = DIM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      adv,
  input  logic [AXES-1:0][CW-1:0]   lim,
  output logic [AXES-1:0][CW-1:0]   cnt
);

  logic [AXES:0]             inc;
  logic [AXES-1:0]           wrap;
  logic [AXES-1:0][CW-1:0]   cnt_nx;

  assign inc[0] = adv;

  for (genvar p = 0; p < AXES; p++) begin : g_pos
    assign wrap[p]  = (cnt[p] == lim[p]);
    assign inc[p+1] = inc[p] & wrap[p];

    always_comb begin
      if (clr)
        cnt_nx[p] = '0;
      else if (inc[p])
        cnt_nx[p] = wrap[p] ? '0 : cnt[p] + 1'b1;
      else
        cnt_nx[p] = cnt[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[p] <= '0;
      else if (clr | inc[p])
        cnt[p] <= cnt_nx[p];
    end

    // R11
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[p] <= lim[p]);
  end

endmodule

// File: rtl/mdr_index_calc.sv
module mdr_index_calc
  import mdr_pkg::*;
#(
  parameter int CW = DIM_W,
  parameter int IW = 19
) (
  input  logic [AXES-1:0][CW-1:0] cnt,
  input  logic [AXES-1:0][CW-1:0] lim,
  input  axis_t [AXES-1:0]        ax,
  input  logic [2:0]              inv,
  input  logic [1:0]              skip,
  input  logic [3:0]              ofs,
  output logic [IW-1:0]           idx
);

  logic [IW-1:0] stride [0:AXES];
  logic [IW-1:0] term   [0:AXES-1];

  assign stride[0] = IW'(1);

  for (genvar p = 0; p < AXES; p++) begin : g_term
    logic [CW-1:0] val;
    logic          keep;
    assign val  = inv[ax[p]] ? (lim[p] - cnt[p]) : cnt[p];
    assign keep = (skip != (ax[p] + 2'd1));
    assign term[p]     = keep ? IW'(val) * stride[p] : '0;
    assign stride[p+1] = keep ? stride[p] * (IW'(lim[p]) + IW'(1)) : stride[p];
  end

  assign idx = term[0] + term[1] + term[2] + IW'(ofs);

endmodule

// File: rtl/mdr_matrix_remap.sv
module mdr_matrix_remap
  import mdr_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int IDX_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [31:0]      shape_i,
  input  logic             step_i,
  output logic             idx_valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  shape_t          shape_q;
  logic [VL_W-1:0] vl_q, step_q, step_n, step_inc;
  logic            act_q, act_n, done_q, done_n;
  logic            adv;

  logic [AXES-1:0][DIM_W-1:0] lim, cnt;
  axis_t [AXES-1:0]           ax;
  logic [IDX_W-1:0]           mat_idx;

  assign adv      = act_q & ~done_q & step_i;
  assign step_inc = step_q + 1'b1;

  always_comb begin
    act_n  = act_q;
    done_n = done_q;
    step_n = step_q;
    if (start_i) begin
      act_n  = 1'b1;
      done_n = (vl_i == '0);
      step_n = '0;
    end else if (adv) begin
      step_n = step_inc;
      done_n = (step_inc == vl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      act_q  <= act_n;
      done_q <= done_n;
      step_q <= step_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shape_q <= '0;
      vl_q    <= '0;
    end else if (start_i) begin
      shape_q <= shape_t'(shape_i);
      vl_q    <= vl_i;
    end
  end

  for (genvar p = 0; p < AXES; p++) begin : g_nest
    assign ax[p]  = nest_axis(shape_q.perm, p);
    assign lim[p] = axis_size(shape_q, ax[p]);
  end

  mdr_nest_walk #(.CW(DIM_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_i),
    .adv   (adv & ~start_i),
    .lim   (lim),
    .cnt   (cnt)
  );

  mdr_index_calc #(.CW(DIM_W), .IW(IDX_W)) u_calc (
    .cnt  (cnt),
    .lim  (lim),
    .ax   (ax),
    .inv  (shape_q.inv),
    .skip (shape_q.skip),
    .ofs  (shape_q.ofs),
    .idx  (mat_idx)
  );

  assign idx_valid_o = act_q & ~done_q;
  assign done_o      = done_q;
  assign idx_o       = (shape_q == '0) ? IDX_W'(step_q) : mat_idx;

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (idx_valid_o || done_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid_o && !step_i && !start_i) |=> (idx_valid_o && $stable(idx_o)));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && !idx_valid_o));

  // R8
  bypass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_q == '0 && adv && !start_i) |=> (done_o || idx_o == $past(idx_o) + 1'b1));

endmodule

// File: tb/mdr_matrix_remap_test.sv
`timescale 1ns/1ps
module mdr_matrix_remap_test;

  localparam int IDX_W = 19;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i, step_i;
  logic [6:0]       vl_i;
  logic [31:0]      shape_i;
  logic             idx_valid_o, done_o;
  logic [IDX_W-1:0] idx_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdr_matrix_remap uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .shape_i(shape_i), .step_i(step_i), .idx_valid_o(idx_valid_o),
    .idx_o(idx_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int xs, input int ys, input int zs,
                                     input int pm, input int iv, input int sk,
                                     input int of);
    return {2'b00, 2'(sk), 4'(of), 3'(iv), 3'(pm), 6'(zs), 6'(ys), 6'(xs)};
  endfunction

  // Expected index from the requirements: decompose the step number.
  function automatic int ref_idx(input logic [31:0] sh, input int s);
    int len [3];
    int ord [3];
    int rem, wt, acc, a, c, v;
    if (sh == 0) return s;
    len[0] = sh[5:0] + 1; len[1] = sh[11:6] + 1; len[2] = sh[17:12] + 1;
    case (sh[20:18])
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      3'd5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    rem = s; wt = 1; acc = 0;
    for (int p = 0; p < 3; p++) begin
      a = ord[p];
      c = rem % len[a];
      rem = rem / len[a];
      v = sh[21+a] ? len[a] - 1 - c : c;
      if (int'(sh[29:28]) != a + 1) begin
        acc += v * wt;
        wt  *= len[a];
      end
    end
    return (acc + int'(sh[27:24])) % (1 << IDX_W);
  endfunction

  task automatic begin_walk(input logic [31:0] sh, input int vl);
    @(negedge clk);
    shape_i = sh; vl_i = 7'(vl); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic walk(input logic [31:0] sh, input int vl, input string req, input bit gaps);
    begin_walk(sh, vl);
    for (int s = 0; s < vl; s++) begin
      chk({req, " valid"}, idx_valid_o, 1);
      chk(req, int'(idx_o), ref_idx(sh, s));
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        chk("R9 hold without step", int'(idx_o), ref_idx(sh, s));
      end
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
    end
    chk("R10 done after length", done_o, 1);
    chk("R10 valid low at done", idx_valid_o, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; step_i = 1'b0; vl_i = '0; shape_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", idx_valid_o, 0);
    chk("R1 done in reset", done_o, 0);
    rst_n = 1'b1;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    chk("R1 valid before start", idx_valid_o, 0);
    chk("R1 done before start", done_o, 0);

    // R8 bypass
    walk(32'h0, 9, "R8 zero shape", 1'b0);
    // R3 plain 3x2x2
    walk(mk(2, 1, 1, 0, 0, 0, 0), 12, "R3 row major", 1'b0);
    // R4 transpose of 3x2
    walk(mk(2, 1, 0, 2, 0, 0, 0), 6, "R4 transpose", 1'b0);
    walk(mk(2, 1, 3, 5, 0, 0, 0), 24, "R4 z innermost", 1'b0);
    walk(mk(2, 1, 0, 7, 0, 0, 0), 6, "R4 code 111 as 000", 1'b0);
    // R6 repeat and modulo
    walk(mk(2, 2, 0, 0, 0, 1, 0), 9, "R6 repeat 000111222", 1'b0);
    walk(mk(2, 0, 1, 0, 0, 3, 0), 6, "R6 modulo 012012", 1'b0);
    // R5 reversed x
    walk(mk(3, 1, 0, 0, 1, 0, 0), 8, "R5 x reversed", 1'b0);
    walk(mk(3, 1, 2, 1, 6, 0, 0), 24, "R5 y z reversed", 1'b0);
    // R7 offset
    walk(mk(2, 0, 0, 0, 0, 0, 15), 3, "R7 offset", 1'b0);
    // R11 cyclic wrap up to 127
    walk(mk(1, 1, 1, 3, 2, 0, 4), 127, "R11 wrap", 1'b0);

    // R10 length zero
    begin_walk(mk(2, 2, 0, 0, 0, 0, 0), 0);
    chk("R10 zero length done", done_o, 1);
    chk("R10 zero length valid", idx_valid_o, 0);
    // R10 done held under step requests
    step_i = 1'b1;
    repeat (3) @(negedge clk);
    step_i = 1'b0;
    chk("R10 done held", done_o, 1);
    chk("R10 idx not valid", idx_valid_o, 0);

    // R2 restart mid walk
    begin_walk(mk(4, 4, 0, 0, 0, 0, 0), 20);
    step_i = 1'b1;
    repeat (3) @(negedge clk);
    step_i = 1'b0;
    chk("R2 mid walk index", int'(idx_o), 3);
    walk(mk(4, 2, 0, 2, 1, 0, 5), 15, "R2 restart", 1'b1);

    // mixed random shapes with gaps
    for (int n = 0; n < 60; n++) begin
      logic [31:0] sh;
      int vl;
      sh = mk($urandom % 5, $urandom % 5, $urandom % 4, $urandom % 8,
              $urandom % 8, $urandom % 4, $urandom % 16);
      vl = 1 + ($urandom % 127);
      walk(sh, vl, "R3 R4 R5 R6 R7 random", 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule